// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only, write-through data cache made of a direct-mapped line array and a small, fully associative victim buffer beside it. Every cache line holds one data word and is named by its line address. A lookup probes only the direct-mapped array, so a hit there is answered in one cycle. When the array misses, the victim buffer is searched in the following cycle. On a victim hit the two lines change places: the requested line returns to its array index, and the line it pushes out takes over the victim slot. No memory traffic is generated. When both structures miss, one request goes to memory. The returned line is installed in the array, and the valid line it evicts is kept in the victim buffer rather than dropped.

The victim buffer only ever receives lines evicted from the array; lines arriving from memory go straight into the array. A victim write goes to a free entry if one exists, and otherwise to the least recently written entry. Two addresses that share an array index therefore stop costing memory round trips once both have been fetched. Three counters report main hits, victim hits and full misses.

Top module: `vc_top`

## Requirements
- R1: While reset is high and right after it, req_ready is 1, resp_valid and mem_req_valid are 0, all three counters read 0 and every line is invalid, so the first access to any address is a full miss.
- R2: A request whose line sits in the direct-mapped array (index = low IDX_W address bits, tag = the rest) gets resp_valid with the stored data one cycle after acceptance, raises no memory request and adds one to cnt_hit.
- R3: A request that misses both structures issues exactly one mem_req_valid pulse carrying the request address. It returns mem_resp_data on resp_data the cycle after mem_resp_valid, adds one to cnt_miss, and leaves the line in the array so a repeat access is a main hit.
- R4: The victim buffer is searched only after the array misses; a victim hit answers two cycles after acceptance with the line's data, issues no memory request and adds one to cnt_vhit.
- R5: On a victim hit the displaced array line takes the hit entry's slot, so an immediate access to the displaced address is itself a victim hit.
- R6: Two addresses with the same index and different tags, accessed alternately, cause memory requests only on their first two accesses; every later alternating access is a victim hit.
- R7: A line evicted by a memory fill is written into an invalid victim entry if one exists, else over the least recently written entry; a line overwritten this way is a full miss on its next access.
- R8: req_ready is 0 from the cycle after a request that misses the array is accepted until its response, and resp_valid is never 1 while req_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Line address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | Response data valid (one cycle) |
| resp_data | output | DATA_W | Returned line |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | ADDR_W | Line address sent to memory |
| mem_resp_valid | input | 1 | Memory returns the requested line |
| mem_resp_data | input | DATA_W | Line from memory |
| cnt_hit | output | CNT_W | Number of direct-mapped hits |
| cnt_vhit | output | CNT_W | Number of victim-buffer hits |
| cnt_miss | output | CNT_W | Number of full misses |

## Verification
The bench uses the default build: an 8-line array, 4 victim entries and 16-bit line addresses. Its memory model answers a fixed 5 cycles after each request. The small index lets two addresses that share an index be built by changing the upper bits. With only four victim entries, six tags at one index plus one leftover entry overflow the buffer. That makes the free-entry-first order, the least-recently-written replacement and the loss of the overwritten line all observable through latency, counters and memory request counts.

// File: rtl/vc_pkg.sv
package vc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_WAIT  = 2'd2
    } vc_state_e;

    localparam int unsigned VC_DEF_ADDR_W = 16;
    localparam int unsigned VC_DEF_DATA_W = 32;
    localparam int unsigned VC_DEF_IDX_W  = 3;
    localparam int unsigned VC_DEF_DEPTH  = 4;
    localparam int unsigned VC_DEF_CNT_W  = 16;

    function automatic int unsigned slot_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/vc_dm_array.sv
module vc_dm_array #(
    parameter int unsigned ADDR_W = vc_pkg::VC_DEF_ADDR_W,
    parameter int unsigned DATA_W = vc_pkg::VC_DEF_DATA_W,
    parameter int unsigned IDX_W  = vc_pkg::VC_DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_line_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned LINES = 1 << IDX_W;
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    logic [LINES-1:0] line_v;
    logic [TAG_W-1:0] line_tag [LINES];
    logic [DATA_W-1:0] line_dat [LINES];

    logic [IDX_W-1:0] ridx, widx;
    assign ridx = rd_addr[IDX_W-1:0];
    assign widx = wr_addr[IDX_W-1:0];

    assign rd_valid     = line_v[ridx];
    assign rd_hit       = line_v[ridx] && (line_tag[ridx] == rd_addr[ADDR_W-1:IDX_W]);
    assign rd_line_addr = {line_tag[ridx], ridx};
    assign rd_data      = line_dat[ridx];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_v <= '0;
        end else if (wr_en) begin
            line_v[widx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_tag[widx] <= wr_addr[ADDR_W-1:IDX_W];
            line_dat[widx] <= wr_data;
        end
    end

endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
    parameter int unsigned ADDR_W = vc_pkg::VC_DEF_ADDR_W,
    parameter int unsigned DATA_W = vc_pkg::VC_DEF_DATA_W,
    parameter int unsigned DEPTH  = vc_pkg::VC_DEF_DEPTH,
    localparam int unsigned SLOT_W = vc_pkg::slot_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] srch_addr,
    output logic              srch_hit,
    output logic [SLOT_W-1:0] srch_slot,
    output logic [DATA_W-1:0] srch_data,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DEPTH-1:0]  ent_v;
    logic [DEPTH-1:0]  match;
    logic [ADDR_W-1:0] ent_a [DEPTH];
    logic [DATA_W-1:0] ent_d [DEPTH];
    logic [SLOT_W-1:0] age   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_v[g] && (ent_a[g] == srch_addr);
    end

    always_comb begin
        srch_hit  = |match;
        srch_slot = '0;
        srch_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                srch_slot = SLOT_W'(i);
                srch_data = ent_d[i];
            end
        end
    end

    // free entry first, otherwise the oldest (age DEPTH-1)
    always_comb begin
        logic found;
        found      = 1'b0;
        alloc_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && !ent_v[i]) begin
                alloc_slot = SLOT_W'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (age[i] == SLOT_W'(DEPTH - 1)) alloc_slot = SLOT_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_v <= '0;
            for (int i = 0; i < DEPTH; i++) age[i] <= SLOT_W'(i);
        end else if (wr_en) begin
            ent_v[wr_slot] <= wr_valid;
            for (int i = 0; i < DEPTH; i++) begin
                if (SLOT_W'(i) == wr_slot)      age[i] <= '0;
                else if (age[i] < age[wr_slot]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_a[wr_slot] <= wr_addr;
            ent_d[wr_slot] <= wr_data;
        end
    end

    // R5: a line is never held twice, so at most one entry matches
    assert_one_match_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R7: a written slot holds exactly the line that was written
    assert_slot_written_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent_v[$past(wr_slot)] == $past(wr_valid)) &&
                  (!$past(wr_valid) || ent_a[$past(wr_slot)] == $past(wr_addr)));

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl #(
    parameter int unsigned ADDR_W = vc_pkg::VC_DEF_ADDR_W,
    parameter int unsigned DATA_W = vc_pkg::VC_DEF_DATA_W,
    parameter int unsigned DEPTH  = vc_pkg::VC_DEF_DEPTH,
    parameter int unsigned CNT_W  = vc_pkg::VC_DEF_CNT_W,
    localparam int unsigned SLOT_W = vc_pkg::slot_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_vhit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic              arr_hit,
    input  logic              arr_valid,
    input  logic [ADDR_W-1:0] arr_line_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic [ADDR_W-1:0] vb_srch_addr,
    input  logic              vb_hit,
    input  logic [SLOT_W-1:0] vb_slot,
    input  logic [DATA_W-1:0] vb_data,
    input  logic [SLOT_W-1:0] vb_alloc,
    output logic              vb_wr_en,
    output logic [SLOT_W-1:0] vb_wr_slot,
    output logic              vb_wr_valid,
    output logic [ADDR_W-1:0] vb_wr_addr,
    output logic [DATA_W-1:0] vb_wr_data
);
    import vc_pkg::*;

    vc_state_e         st;
    logic [ADDR_W-1:0] addr_q;

    assign req_ready    = (st == ST_IDLE);
    assign arr_rd_addr  = (st == ST_IDLE) ? req_addr : addr_q;
    assign vb_srch_addr = addr_q;
    assign arr_wr_addr  = addr_q;
    assign vb_wr_addr   = arr_line_addr;
    assign vb_wr_data   = arr_data;
    assign vb_wr_valid  = arr_valid;

    always_comb begin
        arr_wr_en   = 1'b0;
        arr_wr_data = mem_resp_data;
        vb_wr_en    = 1'b0;
        vb_wr_slot  = vb_alloc;
        if (st == ST_PROBE && vb_hit) begin
            // swap: hit entry goes to the array, displaced line to its slot
            arr_wr_en   = 1'b1;
            arr_wr_data = vb_data;
            vb_wr_en    = 1'b1;
            vb_wr_slot  = vb_slot;
        end else if (st == ST_WAIT && mem_resp_valid) begin
            arr_wr_en = 1'b1;
            vb_wr_en  = arr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            addr_q        <= '0;
            resp_valid    <= 1'b0;
            resp_data     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            cnt_hit       <= '0;
            cnt_vhit      <= '0;
            cnt_miss      <= '0;
        end else begin
            resp_valid    <= 1'b0;
            mem_req_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        if (arr_hit) begin
                            resp_valid <= 1'b1;
                            resp_data  <= arr_data;
                            cnt_hit    <= cnt_hit + 1'b1;
                        end else begin
                            st <= ST_PROBE;
                        end
                    end
                end
                ST_PROBE: begin
                    if (vb_hit) begin
                        resp_valid <= 1'b1;
                        resp_data  <= vb_data;
                        cnt_vhit   <= cnt_vhit + 1'b1;
                        st         <= ST_IDLE;
                    end else begin
                        mem_req_valid <= 1'b1;
                        mem_req_addr  <= addr_q;
                        cnt_miss      <= cnt_miss + 1'b1;
                        st            <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_resp_valid) begin
                        resp_valid <= 1'b1;
                        resp_data  <= mem_resp_data;
                        st         <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4: the victim probe only follows an accepted request that missed the array
    assert_probe_after_miss_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROBE) |-> $past(req_valid && req_ready && !arr_hit));

    // R6: memory is requested only when the victim search also missed
    assert_no_mem_on_vhit_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> $past(st == ST_PROBE && !vb_hit));

    // R3: memory data arrives only while a fill is outstanding
    assert_fill_when_waiting_R3: assert property (@(posedge clk) disable iff (rst)
        mem_resp_valid |-> (st == ST_WAIT));

    // R8: no response is presented while the block is busy
    assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !resp_valid);

endmodule

// File: rtl/vc_top.sv
module vc_top #(
    parameter int unsigned ADDR_W = vc_pkg::VC_DEF_ADDR_W,
    parameter int unsigned DATA_W = vc_pkg::VC_DEF_DATA_W,
    parameter int unsigned IDX_W  = vc_pkg::VC_DEF_IDX_W,
    parameter int unsigned DEPTH  = vc_pkg::VC_DEF_DEPTH,
    parameter int unsigned CNT_W  = vc_pkg::VC_DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_vhit,
    output logic [CNT_W-1:0]  cnt_miss
);
    localparam int unsigned SLOT_W = vc_pkg::slot_bits(DEPTH);

    logic [ADDR_W-1:0] arr_rd_addr, arr_line_addr, arr_wr_addr;
    logic              arr_hit, arr_valid, arr_wr_en;
    logic [DATA_W-1:0] arr_data, arr_wr_data;
    logic [ADDR_W-1:0] vb_srch_addr, vb_wr_addr;
    logic              vb_hit, vb_wr_en, vb_wr_valid;
    logic [SLOT_W-1:0] vb_slot, vb_alloc, vb_wr_slot;
    logic [DATA_W-1:0] vb_data, vb_wr_data;

    vc_dm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst(rst),
        .rd_addr(arr_rd_addr), .rd_hit(arr_hit), .rd_valid(arr_valid),
        .rd_line_addr(arr_line_addr), .rd_data(arr_data),
        .wr_en(arr_wr_en), .wr_addr(arr_wr_addr), .wr_data(arr_wr_data)
    );

    vc_victim_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_victim (
        .clk(clk), .rst(rst),
        .srch_addr(vb_srch_addr), .srch_hit(vb_hit), .srch_slot(vb_slot),
        .srch_data(vb_data), .alloc_slot(vb_alloc),
        .wr_en(vb_wr_en), .wr_slot(vb_wr_slot), .wr_valid(vb_wr_valid),
        .wr_addr(vb_wr_addr), .wr_data(vb_wr_data)
    );

    vc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .cnt_hit(cnt_hit), .cnt_vhit(cnt_vhit), .cnt_miss(cnt_miss),
        .arr_rd_addr(arr_rd_addr), .arr_hit(arr_hit), .arr_valid(arr_valid),
        .arr_line_addr(arr_line_addr), .arr_data(arr_data),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .vb_srch_addr(vb_srch_addr), .vb_hit(vb_hit), .vb_slot(vb_slot),
        .vb_data(vb_data), .vb_alloc(vb_alloc),
        .vb_wr_en(vb_wr_en), .vb_wr_slot(vb_wr_slot), .vb_wr_valid(vb_wr_valid),
        .vb_wr_addr(vb_wr_addr), .vb_wr_data(vb_wr_data)
    );

endmodule

// File: tb/vc_top_bench.sv
`timescale 1ns/1ps
module vc_top_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int MEM_LAT = 5;
    localparam int K_HIT = 0, K_VHIT = 1, K_MISS = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, resp_valid, mem_req_valid;
    logic [DW-1:0] resp_data;
    logic [AW-1:0] mem_req_addr;
    logic          mem_resp_valid = 1'b0;
    logic [DW-1:0] mem_resp_data = '0;
    logic [CW-1:0] cnt_hit, cnt_vhit, cnt_miss;

    vc_top #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3), .DEPTH(4), .CNT_W(CW)) u_vc_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .cnt_hit(cnt_hit), .cnt_vhit(cnt_vhit), .cnt_miss(cnt_miss)
    );

    int checks = 0;
    int failures = 0;
    int memreqs = 0;
    bit done = 1'b0;
    logic [AW-1:0] last_mem_addr = '0;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a, a ^ 16'hA5C3};
    endfunction

    function automatic logic [AW-1:0] at_idx(input int tag, input int idx);
        return AW'((tag << 3) | idx);
    endfunction

    // fixed-latency memory model, sampled and driven at the falling edge
    bit pend = 1'b0;
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (mem_resp_valid) mem_resp_valid = 1'b0;
        if (pend) begin
            if (wait_cnt == 0) begin
                mem_resp_valid = 1'b1;
                mem_resp_data  = mem_word(last_mem_addr);
                pend = 1'b0;
            end else begin
                wait_cnt--;
            end
        end
        if (mem_req_valid && !rst) begin
            pend = 1'b1;
            wait_cnt = MEM_LAT - 1;
            last_mem_addr = mem_req_addr;
            memreqs++;
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input int kind, input string rq);
        int h0, v0, m0, mr0, n;
        h0 = cnt_hit; v0 = cnt_vhit; m0 = cnt_miss; mr0 = memreqs;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        if (kind != K_HIT) check(req_ready == 1'b0, "R8", "ready while busy", req_ready, 0);
        while (!resp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(resp_data == mem_word(a), rq, "response data", resp_data, mem_word(a));
        case (kind)
            K_HIT: begin
                check(n == 1, rq, "main hit latency", n, 1);
                check(cnt_hit == CW'(h0 + 1), rq, "cnt_hit", cnt_hit, h0 + 1);
                check(memreqs == mr0, rq, "memory requests on hit", memreqs, mr0);
            end
            K_VHIT: begin
                check(n == 2, rq, "victim hit latency", n, 2);
                check(cnt_vhit == CW'(v0 + 1), rq, "cnt_vhit", cnt_vhit, v0 + 1);
                check(memreqs == mr0, rq, "memory requests on victim hit", memreqs, mr0);
            end
            default: begin
                check(n >= 3 && n < 200, rq, "miss latency", n, 3 + MEM_LAT);
                check(cnt_miss == CW'(m0 + 1), rq, "cnt_miss", cnt_miss, m0 + 1);
                check(memreqs == mr0 + 1, rq, "memory requests on miss", memreqs, mr0 + 1);
                check(last_mem_addr == a, rq, "memory address", last_mem_addr, a);
            end
        endcase
    endtask

    task automatic t_reset_state();
        check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", mem_req_valid, 0);
        check(cnt_hit == 0 && cnt_vhit == 0 && cnt_miss == 0, "R1", "counters in reset",
              {cnt_hit, cnt_vhit, cnt_miss}, 0);
    endtask

    task automatic t_fill_then_hit();
        access(16'h0001, K_MISS, "R1");
        access(16'h0001, K_HIT, "R3");
        access(16'h0001, K_HIT, "R2");
        access(16'h0042, K_MISS, "R3");
        access(16'h0042, K_HIT, "R2");
    endtask

    task automatic t_conflict_pair();
        logic [AW-1:0] a_addr, b_addr;
        int mr0;
        a_addr = at_idx(32, 5);
        b_addr = at_idx(64, 5);
        mr0 = memreqs;
        access(a_addr, K_MISS, "R3");
        access(b_addr, K_MISS, "R3");
        access(a_addr, K_VHIT, "R4");
        access(b_addr, K_VHIT, "R5");
        access(a_addr, K_VHIT, "R5");
        access(b_addr, K_VHIT, "R6");
        access(a_addr, K_VHIT, "R6");
        check(memreqs == mr0 + 2, "R6", "memory requests for aliasing pair", memreqs, mr0 + 2);
        access(a_addr, K_HIT, "R2");
    endtask

    task automatic t_lru_order();
        // victim holds the pair's other line; six tags at index 6 push five lines
        for (int t = 1; t <= 6; t++) access(at_idx(t, 6), K_MISS, "R7");
        access(at_idx(2, 6), K_VHIT, "R7");
        access(at_idx(1, 6), K_MISS, "R7");
        access(at_idx(64, 5), K_MISS, "R7");
    endtask

    task automatic t_reset_clears();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        access(at_idx(32, 5), K_MISS, "R1");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_fill_then_hit();
        t_conflict_pair();
        t_lru_order();
        t_reset_clears();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule